// File: doc/BRIEF.md
# Vectored Interrupt Controller for an 8-bit Core

This block collects interrupt requests from five sources that sit beside a small 8-bit processor: a falling edge on an external request pin, overflow pulses from two timer/event counters, a real-time clock tick and a dialer I/O event. Each source has a request flag and an enable bit. These bits sit in two 8-bit control/status registers with a global enable, and the core reads and writes them. When a request can be served, the controller pulses a push strobe for the program counter and presents the service address on a vector output.

Taking an interrupt clears the global enable in hardware, so no further interrupt is taken until software sets it again. Software may set it inside a service routine to allow nesting. While the return stack reports full, no request is taken, even an enabled one, and the flag waits. A wake output tells the power logic that an enabled request is pending, whatever the state of the global enable. The core, the stack memory, the timers and the pin synchroniser sit outside this block.

Top module: `irq_ctrl`

## Requirements
- R1: Register 0 (`ctl0`) holds global enable in bit 0, enables for external, timer0 and timer1 in bits 1, 2 and 3, and flags for external, timer0 and timer1 in bits 4, 5 and 6. Bit 7 always reads 0. A write with `wr_sel`=0 loads bits 0 to 6.
- R2: Register 1 (`ctl1`) holds RTC enable in bit 1, dialer enable in bit 2, RTC flag in bit 5 and dialer flag in bit 6. Bits 0 and 4 are spare storage that reads back what was written. Bits 3 and 7 always read 0. A write uses `wr_sel`=1.
- R3: The external flag is set at the clock edge where `ext_irq_n` is low and was high at the previous edge. A pin that stays low sets nothing more.
- R4: The timer0, timer1, RTC and dialer flags are set at any clock edge where their input pulse is high.
- R5: A source is taken only when its flag, its enable and the global enable are all 1, `stack_full` is 0 and no register write happens in that cycle.
- R6: While `stack_full` is 1, nothing is taken and pending flags stay set. The request is taken once the stack has room.
- R7: A take at a clock edge clears that source's flag and the global enable at the same edge, and raises `push_pc` for exactly one cycle after it.
- R8: Vectors are 04H external, 08H timer0, 0CH timer1, 10H RTC and 14H dialer. When several sources are pending, the lowest vector wins. `vector` holds its value until the next take.
- R9: Flags keep latching new requests while the global enable is 0. Setting the global enable again allows the next take, which gives nesting.
- R10: `wake` is 1 one cycle after any flag is set together with its enable, whatever the global enable or `stack_full`.
- R11: A register write wins over a hardware flag set in the same cycle. Writing a flag to 1 forces that request.
- R12: After reset, both registers, `push_pc`, `vector` and `wake` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ext_irq_n | input | 1 | External request pin, already synchronised, active on falling edge |
| tmr0_ovf | input | 1 | Timer0 overflow pulse |
| tmr1_ovf | input | 1 | Timer1 overflow pulse |
| rtc_tick | input | 1 | Real-time clock tick pulse |
| dial_evt | input | 1 | Dialer I/O event pulse |
| stack_full | input | 1 | Return stack has no free entry |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Register select for writes: 0 = ctl0, 1 = ctl1 |
| wr_data | input | 8 | Write data |
| ctl0 | output | 8 | Register 0 contents |
| ctl1 | output | 8 | Register 1 contents |
| push_pc | output | 1 | One-cycle strobe to push the program counter and branch |
| vector | output | 8 | Service address of the last take |
| wake | output | 1 | Enabled request pending, for leaving halt |

## Verification
The assertions check on every cycle that bits which read as zero stay zero and that a push never follows a cycle with the global enable clear, a write or a full stack. They also check that the global enable is clear during every push, that pushes never come on two cycles in a row, that each vector is one of the five legal addresses, and that `wake` follows the enabled pending set by one cycle. Only the bench scenarios can show which source wins a tie, that a flag set while the global enable is clear is later served, that a write beats a same-cycle hardware set, and that a low pin sets the external flag only once. The bench does this with directed sequences and a long random run against a cycle model.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  // Number of request sources; the register layout is built for exactly this count.
  localparam int NSRC = 5;
  // Sources held in register 0; the rest live in register 1.
  localparam int R0_SRC = 3;

  typedef enum logic [2:0] {
    SRC_EXT  = 3'd0,
    SRC_TMR0 = 3'd1,
    SRC_TMR1 = 3'd2,
    SRC_RTC  = 3'd3,
    SRC_DIAL = 3'd4
  } irq_src_e;
endpackage

// File: rtl/irq_capture.sv
// Turns raw request inputs into one-cycle flag set requests.
// Sources marked in FALL_MASK are edge detected on a high-to-low change;
// the others pass straight through as level-per-cycle set requests.
module irq_capture #(
  parameter int          N         = 5,
  parameter logic [N-1:0] FALL_MASK = N'(1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] raw_in,
  output logic [N-1:0] set_req
);
  for (genvar i = 0; i < N; i++) begin : g_src
    if (FALL_MASK[i]) begin : g_fall
      logic prev_q;
      always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b1;
        else     prev_q <= raw_in[i];
      end
      assign set_req[i] = prev_q & ~raw_in[i];
    end else begin : g_lvl
      assign set_req[i] = raw_in[i];
    end
  end
endmodule

// File: rtl/irq_regs.sv
// Holds the global enable, per-source enables and flags, and spare bits.
// A write replaces all fields of the addressed register, overriding any
// hardware update to those fields in that cycle.
module irq_regs
  import irq_ctrl_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  input  logic [NSRC-1:0]  set_req,
  input  logic [NSRC-1:0]  clr_req,
  input  logic             take,
  output logic             gie,
  output logic [NSRC-1:0]  en,
  output logic [NSRC-1:0]  flg,
  output logic [REG_W-1:0] ctl0,
  output logic [REG_W-1:0] ctl1
);
  localparam int R1_SRC = NSRC - R0_SRC;

  logic [1:0] spare_q;
  logic       wr0, wr1;

  assign wr0 = wr_en & ~wr_sel;
  assign wr1 = wr_en &  wr_sel;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie     <= 1'b0;
      en      <= '0;
      flg     <= '0;
      spare_q <= '0;
    end else begin
      gie <= gie & ~take;
      flg <= (flg & ~clr_req) | set_req;
      if (wr0) begin
        gie              <= wr_data[0];
        en[R0_SRC-1:0]   <= wr_data[R0_SRC:1];
        flg[R0_SRC-1:0]  <= wr_data[2*R0_SRC:R0_SRC+1];
      end
      if (wr1) begin
        spare_q[0]         <= wr_data[0];
        en[NSRC-1:R0_SRC]  <= wr_data[R1_SRC:1];
        spare_q[1]         <= wr_data[4];
        flg[NSRC-1:R0_SRC] <= wr_data[4+R1_SRC:5];
      end
    end
  end

  always_comb begin
    ctl0 = '0;
    ctl0[0]                  = gie;
    ctl0[R0_SRC:1]           = en[R0_SRC-1:0];
    ctl0[2*R0_SRC:R0_SRC+1]  = flg[R0_SRC-1:0];
    ctl1 = '0;
    ctl1[0]                  = spare_q[0];
    ctl1[R1_SRC:1]           = en[NSRC-1:R0_SRC];
    ctl1[4]                  = spare_q[1];
    ctl1[4+R1_SRC:5]         = flg[NSRC-1:R0_SRC];
  end
endmodule

// File: rtl/irq_arbiter.sv
// Fixed-priority selection (lowest index wins), take decision,
// registered push strobe, vector and wake outputs.
module irq_arbiter #(
  parameter int N        = 5,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             gie,
  input  logic [N-1:0]     en,
  input  logic [N-1:0]     flg,
  input  logic             stack_full,
  input  logic             wr_en,
  output logic             take,
  output logic [N-1:0]     clr_req,
  output logic             push_pc,
  output logic [VEC_W-1:0] vector,
  output logic             wake
);
  logic [N-1:0]     pend;
  logic [N-1:0]     win_oh;
  logic [VEC_W-1:0] vec_nxt;

  assign pend = flg & en;

  always_comb begin
    win_oh  = '0;
    vec_nxt = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        win_oh  = N'(1) << i;
        vec_nxt = VEC_W'(VEC_BASE + VEC_STEP * i);
      end
    end
  end

  assign take    = gie & (|pend) & ~stack_full & ~wr_en;
  assign clr_req = take ? win_oh : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      push_pc <= 1'b0;
      vector  <= '0;
      wake    <= 1'b0;
    end else begin
      push_pc <= take;
      wake    <= |pend;
      if (take) vector <= vec_nxt;
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int REG_W    = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ext_irq_n,
  input  logic             tmr0_ovf,
  input  logic             tmr1_ovf,
  input  logic             rtc_tick,
  input  logic             dial_evt,
  input  logic             stack_full,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] ctl0,
  output logic [REG_W-1:0] ctl1,
  output logic             push_pc,
  output logic [VEC_W-1:0] vector,
  output logic             wake
);
  localparam logic [NSRC-1:0] FALL_MASK = NSRC'(1) << SRC_EXT;

  logic [NSRC-1:0] raw_in;
  logic [NSRC-1:0] set_req;
  logic [NSRC-1:0] clr_req;
  logic [NSRC-1:0] en;
  logic [NSRC-1:0] flg;
  logic            gie;
  logic            take;

  always_comb begin
    raw_in           = '0;
    raw_in[SRC_EXT]  = ext_irq_n;
    raw_in[SRC_TMR0] = tmr0_ovf;
    raw_in[SRC_TMR1] = tmr1_ovf;
    raw_in[SRC_RTC]  = rtc_tick;
    raw_in[SRC_DIAL] = dial_evt;
  end

  irq_capture #(.N(NSRC), .FALL_MASK(FALL_MASK)) u_cap (
    .clk     (clk),
    .rst     (rst),
    .raw_in  (raw_in),
    .set_req (set_req)
  );

  irq_regs #(.REG_W(REG_W)) u_regs (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .wr_data (wr_data),
    .set_req (set_req),
    .clr_req (clr_req),
    .take    (take),
    .gie     (gie),
    .en      (en),
    .flg     (flg),
    .ctl0    (ctl0),
    .ctl1    (ctl1)
  );

  irq_arbiter #(
    .N(NSRC), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP)
  ) u_arb (
    .clk        (clk),
    .rst        (rst),
    .gie        (gie),
    .en         (en),
    .flg        (flg),
    .stack_full (stack_full),
    .wr_en      (wr_en),
    .take       (take),
    .clr_req    (clr_req),
    .push_pc    (push_pc),
    .vector     (vector),
    .wake       (wake)
  );
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
  parameter int REG_W    = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 4,
  parameter int VEC_STEP = 4,
  parameter int NSRC_C   = 5
) (
  input logic             clk,
  input logic             rst,
  input logic [REG_W-1:0] ctl0,
  input logic [REG_W-1:0] ctl1,
  input logic             stack_full,
  input logic             wr_en,
  input logic             push_pc,
  input logic [VEC_W-1:0] vector,
  input logic             wake
);
  localparam int VEC_MAX = VEC_BASE + VEC_STEP * (NSRC_C - 1);

  logic any_pend;
  int   vec_off;
  assign any_pend = (ctl0[1] & ctl0[4]) | (ctl0[2] & ctl0[5]) | (ctl0[3] & ctl0[6]) |
                    (ctl1[1] & ctl1[5]) | (ctl1[2] & ctl1[6]);
  assign vec_off  = int'(vector) - VEC_BASE;

  AST_CTL0_TOP_ZERO: assert property (@(posedge clk) disable iff (rst) !ctl0[7]); // R1
  AST_CTL1_HOLES_ZERO: assert property (@(posedge clk) disable iff (rst) !ctl1[3] && !ctl1[7]); // R2
  AST_TAKE_NEEDS_GIE: assert property (@(posedge clk) disable iff (rst) push_pc |-> $past(ctl0[0]) && !$past(wr_en)); // R5
  AST_FULL_BLOCKS_TAKE: assert property (@(posedge clk) disable iff (rst) $past(stack_full) |-> !push_pc); // R6
  AST_TAKE_CLEARS_GIE: assert property (@(posedge clk) disable iff (rst) push_pc |-> !ctl0[0]); // R7
  AST_PUSH_SINGLE: assert property (@(posedge clk) disable iff (rst) push_pc |=> !push_pc); // R7
  AST_VECTOR_LEGAL: assert property (@(posedge clk) disable iff (rst) push_pc |-> (int'(vector) >= VEC_BASE) && (int'(vector) <= VEC_MAX) && ((vec_off % VEC_STEP) == 0)); // R8
  AST_WAKE_TRACKS: assert property (@(posedge clk) disable iff (rst) wake == $past(any_pend)); // R10
endmodule

bind irq_ctrl irq_ctrl_chk #(
  .REG_W(REG_W), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .VEC_STEP(VEC_STEP), .NSRC_C(irq_ctrl_pkg::NSRC)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctl0       (ctl0),
  .ctl1       (ctl1),
  .stack_full (stack_full),
  .wr_en      (wr_en),
  .push_pc    (push_pc),
  .vector     (vector),
  .wake       (wake)
);

// File: tb/irq_ctrl_tb.sv
`timescale 1ns/1ps
module irq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       pin = 1'b1, t0 = 1'b0, t1 = 1'b0, rtc = 1'b0, dial = 1'b0;
  logic       sf = 1'b0, we = 1'b0, ws = 1'b0;
  logic [7:0] wd = '0;
  logic [7:0] ctl0, ctl1, vector;
  logic       push_pc, wake;

  int checks = 0, fails = 0;
  bit done = 0;

  // model state
  logic       m_gie;
  logic [4:0] m_en, m_flg;
  logic [1:0] m_spare;
  logic       m_prev;
  logic       e_push, e_wake;
  logic [7:0] e_vec;

  always #10 clk = ~clk;

  irq_ctrl u_dut (
    .clk(clk), .rst(rst), .ext_irq_n(pin), .tmr0_ovf(t0), .tmr1_ovf(t1),
    .rtc_tick(rtc), .dial_evt(dial), .stack_full(sf), .wr_en(we), .wr_sel(ws),
    .wr_data(wd), .ctl0(ctl0), .ctl1(ctl1), .push_pc(push_pc), .vector(vector), .wake(wake)
  );

  function automatic logic [7:0] mk0();
    return {1'b0, m_flg[2:0], m_en[2:0], m_gie};
  endfunction
  function automatic logic [7:0] mk1();
    return {1'b0, m_flg[4:3], m_spare[1], 1'b0, m_en[4:3], m_spare[0]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_gie = 0; m_en = '0; m_flg = '0; m_spare = '0; m_prev = 1;
    e_push = 0; e_wake = 0; e_vec = '0;
  endtask

  // one clock: model the edge, then compare at the following negedge
  task automatic step();
    logic [4:0] pend, set, clr;
    logic       tk;
    int         win;
    pend = m_flg & m_en;
    tk = m_gie & (|pend) & ~sf & ~we;
    win = 0;
    for (int i = 4; i >= 0; i--) if (pend[i]) win = i;
    set = {dial, rtc, t1, t0, m_prev & ~pin};
    clr = tk ? (5'd1 << win) : 5'd0;
    @(posedge clk);
    m_flg = (m_flg & ~clr) | set;
    m_gie = m_gie & ~tk;
    if (we && !ws) begin
      m_gie = wd[0]; m_en[2:0] = wd[3:1]; m_flg[2:0] = wd[6:4];
    end
    if (we && ws) begin
      m_spare[0] = wd[0]; m_en[4:3] = wd[2:1]; m_spare[1] = wd[4]; m_flg[4:3] = wd[6:5];
    end
    e_push = tk;
    if (tk) e_vec = 8'(4 + 4 * win);
    e_wake = |pend;
    m_prev = pin;
    @(negedge clk);
    chk("R1 ctl0", ctl0, mk0());
    chk("R2 ctl1", ctl1, mk1());
    chk("R7 push_pc", push_pc, e_push);
    chk("R8 vector", vector, e_vec);
    chk("R10 wake", wake, e_wake);
  endtask

  task automatic wr(logic sel, logic [7:0] d);
    we = 1; ws = sel; wd = d;
    step();
    we = 0;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1A2B3C));
    model_reset();
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R12 reset state
    chk("R12 ctl0", ctl0, 0); chk("R12 ctl1", ctl1, 0);
    chk("R12 push", push_pc, 0); chk("R12 vector", vector, 0); chk("R12 wake", wake, 0);

    // R4 timer pulse sets flag even when disabled
    t0 = 1; step(); t0 = 0;
    chk("R4 tmr0 flag", ctl0, 8'h20);
    wr(0, 8'h00);

    // R3 falling edge only
    wr(0, 8'h02);
    pin = 0; step();
    chk("R3 fall sets flag", ctl0, 8'h12);
    wr(0, 8'h02);
    step();
    chk("R3 low level no reset", ctl0, 8'h02);
    pin = 1; step();

    // R5 / R10 gie clear blocks take, wake still rises
    wr(0, 8'h12);
    step();
    chk("R5 no take without gie", push_pc, 0);
    chk("R10 wake with gie clear", wake, 1);

    // R6 stack full blocks
    sf = 1;
    wr(0, 8'h13);
    step();
    chk("R6 no push while full", push_pc, 0);
    chk("R6 flag held", ctl0, 8'h13);
    sf = 0;
    step();
    chk("R7 push after room", push_pc, 1);
    chk("R8 ext vector", vector, 8'h04);
    chk("R7 flag and gie cleared", ctl0, 8'h02);
    step();
    chk("R7 single pulse", push_pc, 0);

    // R8 priority, R9 nesting
    wr(1, 8'h66);
    wr(0, 8'h25);
    step();
    chk("R8 timer0 beats rtc", vector, 8'h08);
    chk("R8 ctl1 untouched", ctl1, 8'h66);
    wr(0, 8'h05);
    step();
    chk("R9 retake after gie set", push_pc, 1);
    chk("R9 rtc vector", vector, 8'h10);
    chk("R9 rtc flag cleared", ctl1, 8'h46);
    t1 = 1; step(); t1 = 0;
    chk("R9 latch while gie clear", ctl0, 8'h44);

    // R11 write wins, software force
    rtc = 1; wr(1, 8'h00); rtc = 0;
    chk("R11 write beats set", ctl1, 8'h00);
    wr(0, 8'h49);
    step();
    chk("R11 forced timer1 taken", push_pc, 1);
    chk("R11 timer1 vector", vector, 8'h0C);

    // R2 spare bits and holes, R1 top bit
    wr(1, 8'hFF);
    chk("R2 spare rw holes zero", ctl1, 8'h77);
    wr(1, 8'h00);
    wr(0, 8'h80);
    chk("R1 top bit zero", ctl0, 8'h00);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      sf   = ($urandom % 4) == 0;
      t0   = ($urandom % 8) == 0;
      t1   = ($urandom % 8) == 0;
      rtc  = ($urandom % 8) == 0;
      dial = ($urandom % 8) == 0;
      if (($urandom % 4) == 0) pin = ~pin;
      we   = ($urandom % 10) == 0;
      ws   = $urandom % 2;
      wd   = 8'($urandom);
      if (($urandom % 2) == 0) wd[0] = 1'b1;
      step();
    end
    we = 0; sf = 0; t0 = 0; t1 = 0; rtc = 0; dial = 0;

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule